// File: doc/BRIEF.md
# Monochrome Glyph Expansion Engine

This block turns one-bit-per-pixel glyph bitmaps into full-colour pixels written into a frame memory. Software first loads a foreground and a background colour, a glyph width of up to 32 pixels, a packed start position and a packed position step. It then sends one 32-bit bitmap word per glyph row. The engine paints that row one pixel per clock through a simple pixel-RAM write port. A set bit becomes the foreground colour and a clear bit becomes the background colour. The packed position then moves on by the step value, so the next word lands on the following line without any further set-up.

Glyphs wider than 32 pixels are sent as vertical strips, each with its own start position. The register port has a single ready signal. While a row is still being painted, new writes wait. The port opens again in the cycle that emits the row's final pixel, so consecutive rows stream with no idle cycle between them.

Top module: `glyph_expand`

## Requirements
- R1: After reset the pixel port is idle (`pix_we` low) and `reg_ready` is high. The colours reset to 0, the width to 32, the position to row 0 / column 0, and the step to one row down and zero columns (0x0001_0000).
- R2: Positions and steps are packed with the row in bits 31:16 and the column in bits 15:0. Pixel i of a row is written at column start_col+i (modulo 2^16) on the row start_row.
- R3: Pixel i takes bit 31-i of the row word, so bit 31 is the leftmost pixel. A 1 writes the foreground colour and a 0 writes the background colour.
- R4: A row of width w emits exactly w pixel writes on w consecutive cycles. Bits 31-w down to 0 of the row word have no effect.
- R5: The width register takes `reg_wdata[5:0]`. Any value above 32 is stored as 32.
- R6: Each accepted row word, including one with width 0, adds the step to the position. The row and column fields are added separately, each modulo 2^16.
- R7: Register addresses are: 0 foreground, 1 background, 2 colour pair, 3 width, 4 position, 5 step, 6 row word; address 7 is ignored. A write to address 2 loads the foreground from bits 63:32 and the background from bits 31:0. Single colour writes and the other registers use the low bits.
- R8: A write to the position register replaces the current position. The next row starts there.
- R9: `reg_ready` is low while a row has more than one pixel left to emit. A write presented while `reg_ready` is low has no effect.
- R10: A row word accepted in the cycle that emits the previous row's last pixel starts at once. Its first pixel follows on the very next cycle.
- R11: A row word with width 0 emits no pixel, keeps `reg_ready` high, and still advances the position.
- R12: The first pixel of a row appears on the pixel port in the cycle right after the row word is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write request |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_ready | output | 1 | Write accepted when high together with `reg_we` |
| pix_we | output | 1 | Pixel write strobe |
| pix_x | output | 16 | Pixel column |
| pix_y | output | 16 | Pixel row |
| pix_data | output | 32 | Pixel colour |

## Verification
The delicate cycle is the one in which a row's last pixel goes out while a new register write is accepted. The new write may be a row word that starts the next row, or a colour or position write that must affect only the following row. The bench provokes this by queuing a write while a row is still being painted, so the write lands exactly on the final-pixel cycle. It also sends a raw write during a busy stretch, which must be dropped. A behavioural model predicts the pixel stream and the ready level every cycle. A chained row must show its first pixel with no gap, and the new colour or position must appear only on pixels of the next row.

// File: rtl/glyph_pkg.sv
package glyph_pkg;

    typedef enum logic [2:0] {
        GA_FG   = 3'd0,
        GA_BG   = 3'd1,
        GA_PAIR = 3'd2,
        GA_WID  = 3'd3,
        GA_POS  = 3'd4,
        GA_STEP = 3'd5,
        GA_ROW  = 3'd6,
        GA_NONE = 3'd7
    } glyph_addr_e;

endpackage

// File: rtl/glyph_regs.sv
module glyph_regs
    import glyph_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PIX_W   = 32,
    parameter int COORD_W = 16,
    parameter int ADDR_W  = 3,
    localparam int CNT_W  = $clog2(DATA_W + 1),
    localparam int WD_W   = 2 * PIX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ok,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WD_W-1:0]    wdata,
    output logic [PIX_W-1:0]   fg,
    output logic [PIX_W-1:0]   bg,
    output logic [CNT_W-1:0]   wid,
    output logic [COORD_W-1:0] cur_x,
    output logic [COORD_W-1:0] cur_y,
    output logic               row_go,
    output logic [DATA_W-1:0]  row_bits
);

    typedef struct packed {
        logic [PIX_W-1:0]   fg;
        logic [PIX_W-1:0]   bg;
        logic [CNT_W-1:0]   wid;
        logic [COORD_W-1:0] py;
        logic [COORD_W-1:0] px;
        logic [COORD_W-1:0] sy;
        logic [COORD_W-1:0] sx;
    } rf_t;

    rf_t rf_d, rf_q;
    logic go_d;

    always_comb begin
        rf_d = rf_q;
        go_d = 1'b0;
        if (wr_ok) begin
            case (glyph_addr_e'(addr))
                GA_FG:   rf_d.fg = wdata[PIX_W-1:0];
                GA_BG:   rf_d.bg = wdata[PIX_W-1:0];
                GA_PAIR: begin
                    rf_d.fg = wdata[WD_W-1:PIX_W];
                    rf_d.bg = wdata[PIX_W-1:0];
                end
                GA_WID: begin
                    if (wdata[CNT_W-1:0] > CNT_W'(DATA_W))
                        rf_d.wid = CNT_W'(DATA_W);
                    else
                        rf_d.wid = wdata[CNT_W-1:0];
                end
                GA_POS: begin
                    rf_d.py = wdata[2*COORD_W-1:COORD_W];
                    rf_d.px = wdata[COORD_W-1:0];
                end
                GA_STEP: begin
                    rf_d.sy = wdata[2*COORD_W-1:COORD_W];
                    rf_d.sx = wdata[COORD_W-1:0];
                end
                GA_ROW: begin
                    go_d    = 1'b1;
                    rf_d.py = rf_q.py + rf_q.sy;
                    rf_d.px = rf_q.px + rf_q.sx;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q     <= '0;
            rf_q.wid <= CNT_W'(DATA_W);
            rf_q.sy  <= COORD_W'(1);
        end else begin
            rf_q <= rf_d;
        end
    end

    assign fg       = rf_q.fg;
    assign bg       = rf_q.bg;
    assign wid      = rf_q.wid;
    assign cur_x    = rf_q.px;
    assign cur_y    = rf_q.py;
    assign row_go   = go_d;
    assign row_bits = wdata[DATA_W-1:0];

    // R5
    wid_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_q.wid <= CNT_W'(DATA_W));

    // R6
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_go |=> (rf_q.py == COORD_W'($past(rf_q.py) + $past(rf_q.sy))) &&
                   (rf_q.px == COORD_W'($past(rf_q.px) + $past(rf_q.sx))));

    // R7
    pair_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && addr == ADDR_W'(GA_PAIR)) |=>
            (rf_q.fg == $past(wdata[WD_W-1:PIX_W])) && (rf_q.bg == $past(wdata[PIX_W-1:0])));

endmodule

// File: rtl/glyph_shift.sv
module glyph_shift #(
    parameter int DATA_W  = 32,
    parameter int COORD_W = 16,
    localparam int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [DATA_W-1:0]  bits,
    input  logic [CNT_W-1:0]   wid_in,
    input  logic [COORD_W-1:0] x_in,
    input  logic [COORD_W-1:0] y_in,
    output logic               rdy,
    output logic               pix_we,
    output logic               pix_bit,
    output logic [COORD_W-1:0] pix_x,
    output logic [COORD_W-1:0] pix_y
);

    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   wid;
        logic [DATA_W-1:0]  sh;
        logic [COORD_W-1:0] x0;
        logic [COORD_W-1:0] y0;
    } sh_t;

    sh_t st_d, st_q;
    logic last_px;
    logic start;

    assign last_px = st_q.busy && (st_q.cnt == st_q.wid - CNT_W'(1));
    assign start   = go && (wid_in != '0);

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            st_d.sh  = st_q.sh << 1;
            if (last_px)
                st_d.busy = 1'b0;
        end
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.wid  = wid_in;
            st_d.sh   = bits;
            st_d.x0   = x_in;
            st_d.y0   = y_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rdy     = !st_q.busy || last_px;
    assign pix_we  = st_q.busy;
    assign pix_bit = st_q.sh[DATA_W-1];
    assign pix_x   = st_q.x0 + COORD_W'(st_q.cnt);
    assign pix_y   = st_q.y0;

    // R9
    go_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> !go);

    // R12
    row_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.busy && st_q.cnt == '0));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt < st_q.wid));

    // R10
    chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_px && start) |=> (pix_we && pix_x == $past(x_in)));

endmodule

// File: rtl/glyph_color_sel.sv
module glyph_color_sel #(
    parameter int PIX_W = 32
) (
    input  logic             sel_fg,
    input  logic [PIX_W-1:0] fg,
    input  logic [PIX_W-1:0] bg,
    output logic [PIX_W-1:0] color
);

    always_comb begin
        color = sel_fg ? fg : bg;
    end

endmodule

// File: rtl/glyph_expand.sv
module glyph_expand #(
    parameter int DATA_W  = 32,
    parameter int PIX_W   = 32,
    parameter int COORD_W = 16,
    parameter int ADDR_W  = 3,
    localparam int CNT_W  = $clog2(DATA_W + 1),
    localparam int WD_W   = 2 * PIX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WD_W-1:0]    reg_wdata,
    output logic               reg_ready,
    output logic               pix_we,
    output logic [COORD_W-1:0] pix_x,
    output logic [COORD_W-1:0] pix_y,
    output logic [PIX_W-1:0]   pix_data
);

    logic               wr_ok;
    logic [PIX_W-1:0]   fg, bg;
    logic [CNT_W-1:0]   wid;
    logic [COORD_W-1:0] cur_x, cur_y;
    logic               row_go;
    logic [DATA_W-1:0]  row_bits;
    logic               pix_bit;

    assign wr_ok = reg_we && reg_ready;

    glyph_regs #(
        .DATA_W(DATA_W), .PIX_W(PIX_W), .COORD_W(COORD_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .addr(reg_addr), .wdata(reg_wdata),
        .fg(fg), .bg(bg), .wid(wid), .cur_x(cur_x), .cur_y(cur_y),
        .row_go(row_go), .row_bits(row_bits)
    );

    glyph_shift #(
        .DATA_W(DATA_W), .COORD_W(COORD_W)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .go(row_go), .bits(row_bits), .wid_in(wid),
        .x_in(cur_x), .y_in(cur_y), .rdy(reg_ready), .pix_we(pix_we),
        .pix_bit(pix_bit), .pix_x(pix_x), .pix_y(pix_y)
    );

    glyph_color_sel #(
        .PIX_W(PIX_W)
    ) u_csel (
        .sel_fg(pix_bit), .fg(fg), .bg(bg), .color(pix_data)
    );

endmodule

// File: tb/sim_glyph_expand.sv
`timescale 1ns/1ps
module sim_glyph_expand;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic        reg_ready;
    logic        pix_we;
    logic [15:0] pix_x, pix_y;
    logic [31:0] pix_data;

    always #2 clk = ~clk;

    glyph_expand u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ready(reg_ready), .pix_we(pix_we),
        .pix_x(pix_x), .pix_y(pix_y), .pix_data(pix_data)
    );

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // behavioural model
    logic [31:0] m_fg, m_bg;
    int          m_wid;
    logic [15:0] m_row, m_col, m_srow, m_scol;
    logic [32:0] pq[$];   // {row, col, bit}

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fg = '0; m_bg = '0; m_wid = 32;
            m_row = '0; m_col = '0; m_srow = 16'd1; m_scol = '0;
            pq.delete();
        end else begin
            bit mr;
            mr = (pq.size() <= 1);
            if (pq.size() > 0) void'(pq.pop_front());
            if (reg_we && mr) begin
                case (reg_addr)
                    3'd0: m_fg = reg_wdata[31:0];
                    3'd1: m_bg = reg_wdata[31:0];
                    3'd2: begin m_fg = reg_wdata[63:32]; m_bg = reg_wdata[31:0]; end
                    3'd3: m_wid = (reg_wdata[5:0] > 6'd32) ? 32 : int'(reg_wdata[5:0]);
                    3'd4: begin m_row = reg_wdata[31:16]; m_col = reg_wdata[15:0]; end
                    3'd5: begin m_srow = reg_wdata[31:16]; m_scol = reg_wdata[15:0]; end
                    3'd6: begin
                        for (int i = 0; i < m_wid; i++)
                            pq.push_back({m_row, 16'(m_col + 16'(i)), reg_wdata[31-i]});
                        m_row = m_row + m_srow;
                        m_col = m_col + m_scol;
                    end
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison (R4 strobe count, R2 position, R3 colour, R9 ready)
    always @(negedge clk) begin
        if (rst_n) begin
            bit ew;
            ew = (pq.size() > 0);
            check(pix_we == ew, cur_req, "pix_we(R4)", 64'(pix_we), 64'(ew));
            check(reg_ready == (pq.size() <= 1), cur_req, "reg_ready(R9)",
                  64'(reg_ready), 64'(pq.size() <= 1));
            if (ew && pix_we) begin
                check(pix_y == pq[0][32:17], cur_req, "pix_y(R2)", 64'(pix_y), 64'(pq[0][32:17]));
                check(pix_x == pq[0][16:1], cur_req, "pix_x(R2)", 64'(pix_x), 64'(pq[0][16:1]));
                check(pix_data == (pq[0][0] ? m_fg : m_bg), cur_req, "pix_data(R3)",
                      64'(pix_data), 64'(pq[0][0] ? m_fg : m_bg));
            end
        end
    end

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        while (!reg_ready) @(negedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic drain();
        while (pq.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check(pix_we == 1'b0, "R1", "pix_we after reset", 64'(pix_we), 64'd0);
        check(reg_ready == 1'b1, "R1", "ready after reset", 64'(reg_ready), 64'd1);
        wr(3'd6, 64'h0000_0000_8000_0001);   // defaults: width 32, pos 0, colours 0
        check(pix_we && pix_x == 16'd0 && pix_y == 16'd0, "R1", "default start",
              {pix_y, pix_x}, 64'd0);
        drain();

        cur_req = "R7";
        wr(3'd2, 64'hAAAA_0001_5555_0002);
        cur_req = "R3";
        wr(3'd4, 64'h0000_0000_0005_000A);
        wr(3'd6, 64'h0000_0000_F0F0_1234);
        cur_req = "R12";
        check(pix_we && pix_x == 16'd10 && pix_y == 16'd5, "R12", "first pixel cycle",
              {pix_we, pix_y, pix_x}, {1'b1, 16'd5, 16'd10});
        drain();

        cur_req = "R2";
        wr(3'd3, 64'd8);
        wr(3'd4, 64'h0000_0000_0003_FFFE);
        wr(3'd6, 64'h0000_0000_C300_0000);
        drain();

        cur_req = "R5";
        wr(3'd3, 64'd40);
        wr(3'd6, 64'h0000_0000_DEAD_BEEF);
        drain();
        wr(3'd3, 64'd63);
        wr(3'd6, 64'h0000_0000_0123_4567);
        drain();

        cur_req = "R4";
        wr(3'd0, 64'h0000_0000_00FF_00FF);
        wr(3'd3, 64'd5);
        wr(3'd6, 64'h0000_0000_AFFF_FFFF);
        drain();

        cur_req = "R6";
        wr(3'd5, 64'h0000_0000_0002_FFFF);
        wr(3'd4, 64'h0000_0000_FFFF_0004);
        wr(3'd6, 64'h0000_0000_9000_0000);
        wr(3'd6, 64'h0000_0000_6000_0000);
        wr(3'd6, 64'h0000_0000_F800_0000);
        drain();

        cur_req = "R8";
        wr(3'd5, 64'h0000_0000_0001_0000);
        wr(3'd3, 64'd16);
        wr(3'd6, 64'h0000_0000_1234_5678);
        wr(3'd4, 64'h0000_0000_0100_0200);   // waits for last pixel
        wr(3'd6, 64'h0000_0000_8765_4321);
        drain();

        cur_req = "R9";
        wr(3'd3, 64'd32);
        wr(3'd6, 64'h0000_0000_FFFF_0000);
        repeat (3) @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 64'h0000_0000_0777_0777;
        @(negedge clk);
        reg_we = 1'b0;
        drain();
        wr(3'd6, 64'h0000_0000_0F0F_0F0F);   // must start from the stepped position
        drain();

        cur_req = "R10";
        wr(3'd3, 64'd4);
        wr(3'd6, 64'h0000_0000_A000_0000);
        wr(3'd6, 64'h0000_0000_5000_0000);
        check(pix_we && pix_x == 16'h0200, "R10", "chained row first pixel",
              {pix_we, pix_x}, {1'b1, 16'h0200});
        wr(3'd1, 64'h0000_0000_1357_9BDF);   // colour change on final pixel cycle
        wr(3'd6, 64'h0000_0000_3000_0000);
        drain();

        cur_req = "R11";
        wr(3'd3, 64'd0);
        wr(3'd6, 64'h0000_0000_FFFF_FFFF);
        check(pix_we == 1'b0 && reg_ready == 1'b1, "R11", "zero-width row idle",
              {pix_we, reg_ready}, 2'b01);
        wr(3'd3, 64'd3);
        wr(3'd6, 64'h0000_0000_E000_0000);
        drain();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule